// File: doc/BRIEF.md
# Buck Converter Start-Up and Fault Sequencer

This block is the digital sequencer of a synchronous step-down controller. After a supply-ready reset it probes for the input supply: it pulses the high-side gate request at a low rate and counts how often the sense comparator changes level. Four such changes, rising or falling, show that the input supply is present. The block then runs a soft start. A counter ramps a digital reference code from zero to full scale while PWM is enabled. After that the converter stays in regulation.

In regulation the block watches three fault flags. An over-current flag acts at once. The two undervoltage flags, one for the switcher feedback and one for the linear-regulator feedback, must stay high for a qualification time before they act. Each fault starts a hiccup: the gates go off, the ramp timer runs once with PWM disabled, and then a fresh soft start begins. The fourth trip in a row latches the block off if the cause is over-current or linear undervoltage. If the cause is switcher undervoltage, the fourth trip sends the block back to supply probing. A long enough fault-free run clears the trip count.

A low level on the shutdown input forces every output off. The analog comparators, the error amplifier, the ramp and the gate drivers are outside the block.

Top module: `buck_seq_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, `pwm_en`, `latched_off` and `ss_code` are all zero and the block is probing for the input supply.
- R2: While probing, `hs_probe` is high for exactly PROBE_HIGH cycles in every PROBE_PERIOD cycles. It is never high while `pwm_en` is high.
- R3: While probing, each change of `sense_hi` counts as one crossing, whether rising or falling. The fourth crossing starts a soft start: `pwm_en` rises at that clock edge. Three crossings leave `pwm_en` low.
- R4: During soft start `ss_code` begins at 0, rises by one every SS_STEP cycles and never falls. One cycle after it reaches the all-ones value, regulation begins. With SS_STEP=3 and a 4-bit code, the all-ones value is reached 45 cycles after the start edge.
- R5: In regulation, an undervoltage flag (`uv_sw` or `uv_lin`) trips only after UV_QUAL consecutive high cycles, so a shorter pulse has no effect. `oc_flag` trips on its first high cycle.
- R6: All fault flags are ignored during soft start and during a hiccup.
- R7: A trip that is not the fourth consecutive one clears `pwm_en`. The ramp then runs from 0 to full scale with `pwm_en` low, after which a new soft start begins.
- R8: On the fourth consecutive trip caused by `oc_flag` or `uv_lin`, `latched_off` goes to 1 while `pwm_en` and `ss_code` go to 0. When flags trip together, the priority is oc_flag over uv_lin over uv_sw.
- R9: On the fourth consecutive trip caused by `uv_sw` alone, the block returns to supply probing instead of latching, with `latched_off` low and `hs_probe` active. The trip count is cleared.
- R10: CLEAN_CYC consecutive cycles in regulation clear the trip count, so the next trip only starts a hiccup.
- R11: A low `shdn_n` forces `pwm_en`, `hs_probe`, `ss_code` and `latched_off` to 0 at the next edge. Releasing `shdn_n` restarts supply probing.
- R12: Once set, `latched_off` stays high until `shdn_n` is pulled low or `rst` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Supply-ready reset, synchronous, active high |
| shdn_n | input | 1 | Shutdown request, active low |
| sense_hi | input | 1 | Sense-node comparator output |
| oc_flag | input | 1 | Over-current comparator flag |
| uv_sw | input | 1 | Switcher feedback undervoltage flag |
| uv_lin | input | 1 | Linear feedback undervoltage flag |
| hs_probe | output | 1 | High-side gate request carrying the supply probe pulse |
| ss_code | output | SS_W | Soft-start reference code |
| pwm_en | output | 1 | PWM enable |
| latched_off | output | 1 | Latched-off status |

## Verification
The bench builds the block with the following values:

| Parameter | Bench value |
|---|---|
| PROBE_PERIOD | 20 |
| PROBE_HIGH | 2 |
| SS_W | 4 |
| SS_STEP | 3 |
| UV_QUAL | 8 |
| CLEAN_CYC | 30 |

With these values a whole soft start or hiccup ramp lasts 46 cycles. Four hiccup cycles in a row, ending in latch-off or in a return to probing, therefore fit in a few hundred cycles. The undervoltage qualifier can be tested at exactly one cycle short of its limit and at the limit itself. The clean-run window is short enough to be exceeded on purpose between trips, and the trips in the latch test come quickly enough to stay inside it.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;
  typedef enum logic [2:0] {
    ST_SENSE  = 3'd0,
    ST_SOFT   = 3'd1,
    ST_RUN    = 3'd2,
    ST_HICCUP = 3'd3,
    ST_LATCH  = 3'd4,
    ST_OFF    = 3'd5
  } seq_state_t;
endpackage

// File: rtl/buck_seq_probe.sv
module buck_seq_probe #(
  parameter int PERIOD = 5000,
  parameter int HIGH   = 50,
  parameter int EDGES  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic gen_en,
  input  logic cnt_en,
  input  logic sense_i,
  output logic probe_o,
  output logic ready_o
);
  localparam int PW = $clog2(PERIOD);
  localparam int EW = $clog2(EDGES + 1);

  logic [PW-1:0] per_cnt;
  logic [EW-1:0] edge_cnt;
  logic          sense_q;
  logic          edge_seen;

  assign edge_seen = cnt_en && (sense_i != sense_q);
  assign ready_o   = edge_seen && (edge_cnt == EW'(EDGES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      per_cnt  <= '0;
      edge_cnt <= '0;
      sense_q  <= 1'b0;
      probe_o  <= 1'b0;
    end else begin
      sense_q <= sense_i;
      // probe period counter
      if (!gen_en || per_cnt == PW'(PERIOD - 1)) per_cnt <= '0;
      else                                       per_cnt <= per_cnt + 1'b1;
      probe_o <= gen_en && (per_cnt < PW'(HIGH));
      // crossing counter
      if (!cnt_en)        edge_cnt <= '0;
      else if (edge_seen) edge_cnt <= edge_cnt + 1'b1;
    end
  end

  // R2: a probe pulse only follows an enabled probe window
  a_r2_probe_gated: assert property (@(posedge clk) disable iff (rst)
    probe_o |-> $past(gen_en));
endmodule

// File: rtl/buck_seq_ramp.sv
module buck_seq_ramp #(
  parameter int W    = 8,
  parameter int STEP = 625
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         run,
  output logic [W-1:0] code_o,
  output logic         done_o
);
  localparam int SW = $clog2(STEP);
  localparam logic [W-1:0] FULL = {W{1'b1}};

  logic [SW-1:0] step_cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      step_cnt <= '0;
      code_o   <= '0;
    end else if (run) begin
      if (step_cnt == SW'(STEP - 1)) begin
        step_cnt <= '0;
        if (code_o != FULL) code_o <= code_o + 1'b1;
      end else begin
        step_cnt <= step_cnt + 1'b1;
      end
    end
  end

  assign done_o = (code_o == FULL);

  // R4: the ramp never falls and moves by at most one code per cycle
  a_r4_ramp_monotonic: assert property (@(posedge clk) disable iff (rst)
    (run && !clear) |=> (code_o >= $past(code_o)) && ((code_o - $past(code_o)) <= W'(1)));
endmodule

// File: rtl/buck_seq_uvq.sv
module buck_seq_uvq #(
  parameter int QUAL = 1500
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic flag_i,
  output logic trip_o
);
  localparam int QW = $clog2(QUAL + 1);

  logic [QW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en || !flag_i) cnt <= '0;
    else if (cnt != QW'(QUAL)) cnt <= cnt + 1'b1;
  end

  assign trip_o = (cnt == QW'(QUAL));

  // R5: a qualified trip needs the flag held high in the cycle before
  a_r5_trip_after_flag: assert property (@(posedge clk) disable iff (rst)
    trip_o |-> ($past(flag_i) && $past(en)));
endmodule

// File: rtl/buck_seq_ctrl.sv
module buck_seq_ctrl
  import buck_seq_pkg::*;
#(
  parameter int PROBE_PERIOD = 5000,
  parameter int PROBE_HIGH   = 50,
  parameter int EDGES        = 4,
  parameter int SS_W         = 8,
  parameter int SS_STEP      = 625,
  parameter int UV_QUAL      = 1500,
  parameter int HICCUP_MAX   = 4,
  parameter int CLEAN_CYC    = 50000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            shdn_n,
  input  logic            sense_hi,
  input  logic            oc_flag,
  input  logic            uv_sw,
  input  logic            uv_lin,
  output logic            hs_probe,
  output logic [SS_W-1:0] ss_code,
  output logic            pwm_en,
  output logic            latched_off
);
  localparam int HW = $clog2(HICCUP_MAX + 1);
  localparam int CW = $clog2(CLEAN_CYC + 1);
  localparam logic [HW-1:0] HIC_LAST = HW'(HICCUP_MAX - 1);

  seq_state_t    state, nx;
  logic          ready, ss_done, ss_clear, ss_run;
  logic [1:0]    uv_flags, uv_trip;
  logic          lin_trip, sw_trip, hard_fault, fault_any;
  logic [HW-1:0] hic_cnt;
  logic [CW-1:0] clean_cnt;

  buck_seq_probe #(.PERIOD(PROBE_PERIOD), .HIGH(PROBE_HIGH), .EDGES(EDGES)) probe_i (
    .clk(clk), .rst(rst), .gen_en(nx == ST_SENSE), .cnt_en(state == ST_SENSE),
    .sense_i(sense_hi), .probe_o(hs_probe), .ready_o(ready));

  assign ss_run   = (state == ST_SOFT) || (state == ST_HICCUP);
  assign ss_clear = (nx != state) && (nx != ST_RUN);

  buck_seq_ramp #(.W(SS_W), .STEP(SS_STEP)) ramp_i (
    .clk(clk), .rst(rst), .clear(ss_clear), .run(ss_run),
    .code_o(ss_code), .done_o(ss_done));

  // one qualifier per undervoltage flag: index 0 switcher, 1 linear
  assign uv_flags = {uv_lin, uv_sw};
  for (genvar g = 0; g < 2; g++) begin : g_uvq
    buck_seq_uvq #(.QUAL(UV_QUAL)) uvq_i (
      .clk(clk), .rst(rst), .en(state == ST_RUN),
      .flag_i(uv_flags[g]), .trip_o(uv_trip[g]));
  end

  assign sw_trip    = uv_trip[0];
  assign lin_trip   = uv_trip[1];
  assign hard_fault = oc_flag || lin_trip;
  assign fault_any  = hard_fault || sw_trip;

  always_comb begin
    nx = state;
    unique case (state)
      ST_SENSE:  if (ready)   nx = ST_SOFT;
      ST_SOFT:   if (ss_done) nx = ST_RUN;
      ST_RUN: begin
        if (fault_any) begin
          if (hic_cnt == HIC_LAST) nx = hard_fault ? ST_LATCH : ST_SENSE;
          else                     nx = ST_HICCUP;
        end
      end
      ST_HICCUP: if (ss_done) nx = ST_SOFT;
      ST_LATCH:  nx = ST_LATCH;
      ST_OFF:    nx = ST_SENSE;
      default:   nx = ST_OFF;
    endcase
    if (!shdn_n) nx = ST_OFF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_SENSE;
      hic_cnt     <= '0;
      clean_cnt   <= '0;
      pwm_en      <= 1'b0;
      latched_off <= 1'b0;
    end else begin
      state       <= nx;
      pwm_en      <= (nx == ST_SOFT) || (nx == ST_RUN);
      latched_off <= (nx == ST_LATCH);
      // clean-run window
      if (state != ST_RUN)                clean_cnt <= '0;
      else if (clean_cnt != CW'(CLEAN_CYC)) clean_cnt <= clean_cnt + 1'b1;
      // consecutive trip count
      if (!shdn_n) begin
        hic_cnt <= '0;
      end else if (state == ST_RUN && fault_any) begin
        if (hic_cnt != HIC_LAST) hic_cnt <= hic_cnt + 1'b1;
        else if (!hard_fault)    hic_cnt <= '0;
      end else if (state == ST_RUN && clean_cnt >= CW'(CLEAN_CYC - 1)) begin
        hic_cnt <= '0;
      end
    end
  end

  // R8: a latched block never enables PWM
  a_r8_latch_no_pwm: assert property (@(posedge clk) disable iff (rst)
    latched_off |-> !pwm_en);
  // R8: the trip count stays inside its range
  a_r8_hic_bound: assert property (@(posedge clk) disable iff (rst)
    hic_cnt <= HIC_LAST);
  // R2: probing and switching are exclusive
  a_r2_probe_excl: assert property (@(posedge clk) disable iff (rst)
    hs_probe |-> !pwm_en);
  // R11: shutdown clears every output at the next edge
  a_r11_shutdown_off: assert property (@(posedge clk) disable iff (rst)
    !shdn_n |=> (!pwm_en && !hs_probe && !latched_off && ss_code == '0));
  // R12: latch-off only releases through shutdown or reset
  a_r12_latch_release: assert property (@(posedge clk) disable iff (rst)
    $fell(latched_off) |-> (!$past(shdn_n) || $past(rst)));
endmodule

// File: tb/buck_seq_ctrl_tb_top.sv
module buck_seq_ctrl_tb_top;
  localparam int PP = 20, PH = 2, SSW = 4, SST = 3, UVQ = 8, CLN = 30;
  localparam logic [SSW-1:0] FULL = {SSW{1'b1}};
  // stimulus table: kind 0 uv_sw, 1 uv_lin, 2 oc_flag, 3 none
  localparam int NV = 6;
  localparam int T_KIND [NV] = '{0, 0, 1, 1, 2, 3};
  localparam int T_LEN  [NV] = '{UVQ - 1, UVQ, UVQ - 1, UVQ, 1, UVQ};
  localparam bit T_TRIP [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};

  logic clk = 1'b0, rst = 1'b1, shdn_n = 1'b1, sense_hi = 1'b0;
  logic oc_flag = 1'b0, uv_sw = 1'b0, uv_lin = 1'b0;
  logic hs_probe, pwm_en, latched_off;
  logic [SSW-1:0] ss_code;
  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  buck_seq_ctrl #(.PROBE_PERIOD(PP), .PROBE_HIGH(PH), .EDGES(4), .SS_W(SSW),
    .SS_STEP(SST), .UV_QUAL(UVQ), .HICCUP_MAX(4), .CLEAN_CYC(CLN)) dut_i (
    .clk(clk), .rst(rst), .shdn_n(shdn_n), .sense_hi(sense_hi), .oc_flag(oc_flag),
    .uv_sw(uv_sw), .uv_lin(uv_lin), .hs_probe(hs_probe), .ss_code(ss_code),
    .pwm_en(pwm_en), .latched_off(latched_off));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; shdn_n = 1'b1;
    oc_flag = 1'b0; uv_sw = 1'b0; uv_lin = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic toggle_sense(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sense_hi = ~sense_hi;
      @(negedge clk);
    end
  endtask

  task automatic wait_run();
    do @(negedge clk); while (!(pwm_en && ss_code == FULL));
    @(negedge clk);
  endtask

  task automatic bring_up();
    do_reset();
    toggle_sense(4);
    wait_run();
  endtask

  task automatic pulse(input int kind, input int len);
    @(negedge clk);
    case (kind)
      0: uv_sw = 1'b1;
      1: uv_lin = 1'b1;
      2: oc_flag = 1'b1;
      default: ;
    endcase
    repeat (len) @(negedge clk);
    uv_sw = 1'b0; uv_lin = 1'b0; oc_flag = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  function automatic int probe_count();
    return 0;
  endfunction

  task automatic count_probe(output int hi);
    hi = 0;
    for (int i = 0; i < 2 * PP; i++) begin
      @(negedge clk);
      if (hs_probe) hi++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int hi, c, prev;
    bit drop, mono_bad;

    // table walk: R5 qualification and oc immediacy
    for (int v = 0; v < NV; v++) begin
      bring_up();
      pulse(T_KIND[v], T_LEN[v]);
      chk(pwm_en == !T_TRIP[v], "R5 fault qualification", int'(pwm_en), int'(!T_TRIP[v]));
    end

    // R1 reset state
    do_reset();
    @(negedge clk);
    chk(!pwm_en && !latched_off && ss_code == 0, "R1 reset outputs",
        int'({pwm_en, latched_off}) + int'(ss_code), 0);

    // R2 probe duty
    count_probe(hi);
    chk(hi == 2 * PH, "R2 probe duty", hi, 2 * PH);

    // R3 three crossings do not start
    toggle_sense(3);
    repeat (2) @(negedge clk);
    chk(!pwm_en, "R3 three crossings", int'(pwm_en), 0);

    // R3/R4/R6 fourth crossing, ramp timing, faults ignored in soft start
    @(negedge clk); sense_hi = ~sense_hi;
    c = 0; prev = 0; drop = 1'b0; mono_bad = 1'b0;
    do begin
      @(negedge clk);
      c++;
      oc_flag = (c >= 10 && c < 20);
      uv_lin = (c >= 10 && c < 30);
      if (!pwm_en) drop = 1'b1;
      if (int'(ss_code) < prev) mono_bad = 1'b1;
      prev = int'(ss_code);
    end while (ss_code != FULL && c < 200);
    oc_flag = 1'b0; uv_lin = 1'b0;
    chk(!drop, "R3 fourth crossing starts pwm", int'(drop), 0);
    chk(!mono_bad, "R4 ramp monotonic", int'(mono_bad), 0);
    chk(c >= 45 && c <= 47, "R4 ramp length", c, 46);
    @(negedge clk);
    chk(pwm_en, "R6 faults ignored in soft start", int'(pwm_en), 1);

    // R7 hiccup with outputs off then restart
    pulse(2, 1);
    chk(!pwm_en, "R7 hiccup gates off", int'(pwm_en), 0);
    uv_sw = 1'b1;
    repeat (20) @(negedge clk);
    uv_sw = 1'b0;
    chk(!pwm_en && ss_code > 0, "R7 ramp runs with pwm off", int'(ss_code), 7);
    wait_run();
    chk(pwm_en && !latched_off, "R7 restart after hiccup", int'(pwm_en), 1);

    // R8 latch after four oc trips
    bring_up();
    for (int k = 0; k < 4; k++) begin
      pulse(2, 1);
      if (k < 3) begin
        chk(!latched_off && !pwm_en, "R8 no latch before fourth", int'(latched_off), 0);
        wait_run();
      end
    end
    chk(latched_off && !pwm_en && ss_code == 0, "R8 latched off", int'(latched_off), 1);
    repeat (20) @(negedge clk);
    chk(latched_off && !hs_probe, "R12 latch holds", int'(latched_off), 1);

    // R11/R12 shutdown clears latch
    shdn_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(!latched_off && !pwm_en && !hs_probe && ss_code == 0, "R12 shutdown releases latch",
        int'(latched_off), 0);
    shdn_n = 1'b1;
    count_probe(hi);
    chk(hi == 2 * PH, "R11 probing restarts", hi, 2 * PH);

    // R11 shutdown during regulation
    bring_up();
    shdn_n = 1'b0;
    @(negedge clk);
    chk(!pwm_en && !hs_probe && ss_code == 0, "R11 shutdown in run", int'(pwm_en), 0);
    shdn_n = 1'b1;

    // R9 switcher undervoltage returns to probing
    bring_up();
    for (int k = 0; k < 4; k++) begin
      pulse(0, UVQ);
      if (k < 3) wait_run();
    end
    chk(!pwm_en && !latched_off, "R9 no latch on switcher uv", int'(latched_off), 0);
    count_probe(hi);
    chk(hi == 2 * PH, "R9 probing after switcher uv", hi, 2 * PH);

    // R10 clean run window clears the count
    bring_up();
    for (int k = 0; k < 3; k++) begin
      pulse(2, 1);
      wait_run();
    end
    repeat (CLN + 10) @(negedge clk);
    pulse(2, 1);
    chk(!latched_off && !pwm_en, "R10 count cleared after clean run", int'(latched_off), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule